// File: doc/BRIEF.md
# Kick-Triggered Rate Control Registers

This block keeps the division codes for a group of derived clocks. Software programs new codes into three staged registers through a small request/response port. These writes have no effect on the clock tree. Software then writes a one to the kick bit. When the kick is accepted, the block captures every staged code at once. After a fixed number of cycles it moves all of the captured codes into the active outputs on a single edge. On that same edge the kick bit clears itself. Software polls the kick bit to learn when the update has finished. While the bit reads one, software treats the block as busy.

The request channel is valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Only reads return a response, and the response channel is also valid/ready. A response that is not taken is held unchanged. `req_ready` stays low until that response has been consumed, so a stalled reader throttles new requests. Writes are acknowledged only by their acceptance. The active codes are visible on plain output pins, which also serve as a debug view of the applied settings.

Top module: `rate_kick_regs`

## Requirements
- R1: After reset, all staged and active codes are zero, `kick_busy` is low, `rsp_valid` is low and `req_ready` is high.
- R2: Register layout and staging. Register 0 holds five 4-bit codes at bits 23:20, 15:12, 11:8, 7:4 and 3:0. Register 1 holds three 4-bit codes at bits 15:12, 11:8 and 7:4, and bit 31 is the kick bit. Register 2 holds two 5-bit codes at bits 12:8 and 4:0. A write loads every code field of the addressed register. A read returns the staged codes with all other bits zero, except bit 31 of register 1, which reads the busy state. Address 3 reads zero and ignores writes.
- R3: Staged writes never change `act_div` or `act_frac` unless a kick completes.
- R4: A write to register 1 with bit 31 set, accepted while idle, starts a kick. `kick_busy` and read-back bit 31 are high from the next cycle.
- R5: Exactly LATENCY (default 8) rising edges after the accepting edge, all active codes change on one edge, and `kick_busy` falls on that same edge.
- R6: The applied codes are the staged codes as they stand right after the kick write, including the codes carried by that write. `act_div` packs the register 0 fields in the order 23:20, 15:12, 11:8, 7:4, 3:0 into slices 0 to 4, and the register 1 fields 15:12, 11:8, 7:4 into slices 5 to 7. Slice k is `act_div[4k+3:4k]`. `act_frac[4:0]` holds bits 12:8 of register 2, and `act_frac[9:5]` holds bits 4:0.
- R7: Writes accepted while a kick is pending update the staged codes. They reach the active outputs only with a later kick.
- R8: A kick request written while a kick is pending neither restarts nor extends the pending update. That write's code fields are still staged.
- R9: A read response is presented one cycle after acceptance. It is held with stable data while `rsp_ready` is low, and during that time `req_ready` is low. Writes produce no response.
- R10: A write to register 1 with bit 31 clear does not start a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Reader takes the read data |
| rsp_rdata | output | 32 | Read data |
| kick_busy | output | 1 | Kick pending |
| act_div | output | 32 | Eight active 4-bit division codes |
| act_frac | output | 10 | Two active 5-bit fractional codes |

## Verification
The register layout is exercised with three patterns. All-ones writes show the field masks. Distinct per-field values show that each field lands in its own slice. Address 3 checks decoding. Kick behaviour is probed cycle by cycle: one edge before completion the old codes must still be present, and on the completion edge the new codes must appear. This separates a correct latency from an off-by-one error. Writes and a second kick issued during the pending window distinguish snapshot-at-kick from copy-at-completion, and show that no restart happens. A stalled reader checks that the response is held and that request acceptance is throttled.

// File: rtl/rkr_pkg.sv
package rkr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int NUM_DIV  = 8;
  localparam int DIV_W    = 4;
  localparam int NUM_FRAC = 2;
  localparam int FRAC_W   = 5;
  localparam int KICK_BIT = 31;
  localparam int DIV_VW   = NUM_DIV * DIV_W;
  localparam int FRAC_VW  = NUM_FRAC * FRAC_W;

  localparam logic [ADDR_W-1:0] REG_MAIN = 2'd0;
  localparam logic [ADDR_W-1:0] REG_AUX  = 2'd1;
  localparam logic [ADDR_W-1:0] REG_FRAC = 2'd2;

  // bit offset of division field i inside its register
  function automatic int div_off(input int i);
    case (i)
      0: return 20;
      1: return 12;
      2: return 8;
      3: return 4;
      4: return 0;
      5: return 12;
      6: return 8;
      default: return 4;
    endcase
  endfunction

  // register that holds division field i
  function automatic logic [ADDR_W-1:0] div_reg(input int i);
    return (i < 5) ? REG_MAIN : REG_AUX;
  endfunction

  function automatic int frac_off(input int j);
    return (j == 0) ? 8 : 0;
  endfunction
endpackage

// File: rtl/rkr_bus_port.sv
module rkr_bus_port
  import rkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign wr_addr   = req_addr;
  assign wr_data   = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response stays put
  a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R9: writes never produce a response
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/rkr_shadow.sv
module rkr_shadow
  import rkr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               busy,
  output logic [DATA_W-1:0]  rd_data,
  output logic [DIV_VW-1:0]  div_next,
  output logic [FRAC_VW-1:0] frac_next,
  output logic               kick_req
);
  logic [DIV_VW-1:0]  div_q;
  logic [FRAC_VW-1:0] frac_q;

  assign kick_req = wr_en && (wr_addr == REG_AUX) && wr_data[KICK_BIT];

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int               OFF = div_off(i);
    localparam logic [ADDR_W-1:0] RG = div_reg(i);
    assign div_next[i*DIV_W +: DIV_W] = (wr_en && wr_addr == RG) ?
      wr_data[OFF +: DIV_W] : div_q[i*DIV_W +: DIV_W];
  end

  for (genvar j = 0; j < NUM_FRAC; j++) begin : g_frac
    localparam int OFF = frac_off(j);
    assign frac_next[j*FRAC_W +: FRAC_W] = (wr_en && wr_addr == REG_FRAC) ?
      wr_data[OFF +: FRAC_W] : frac_q[j*FRAC_W +: FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      frac_q <= '0;
    end else begin
      div_q  <= div_next;
      frac_q <= frac_next;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (rd_addr == div_reg(i))
        rd_data[div_off(i) +: DIV_W] = div_q[i*DIV_W +: DIV_W];
    end
    for (int j = 0; j < NUM_FRAC; j++) begin
      if (rd_addr == REG_FRAC)
        rd_data[frac_off(j) +: FRAC_W] = frac_q[j*FRAC_W +: FRAC_W];
    end
    if (rd_addr == REG_AUX)
      rd_data[KICK_BIT] = busy;
  end

  // R2: staged codes move only on an accepted write
  a_r2_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(div_q) && $stable(frac_q));
endmodule

// File: rtl/rkr_kick_seq.sv
module rkr_kick_seq #(
  parameter int LATENCY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_req,
  output logic busy,
  output logic start,
  output logic done
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  assign start = kick_req && !busy;
  assign done  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R4: an accepted kick raises busy with a full window
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && cnt == CNT_LOAD);
  // R5, R8: the window counts down without restart
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy && cnt == $past(cnt) - 1'b1);
  // R5: busy drops right after the final cycle
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/rkr_active.sv
module rkr_active
  import rkr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               done,
  input  logic [DIV_VW-1:0]  div_next,
  input  logic [FRAC_VW-1:0] frac_next,
  output logic [DIV_VW-1:0]  act_div,
  output logic [FRAC_VW-1:0] act_frac
);
  logic [DIV_VW-1:0]  snap_div;
  logic [FRAC_VW-1:0] snap_frac;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        snap_div[i*DIV_W +: DIV_W] <= '0;
        act_div[i*DIV_W +: DIV_W]  <= '0;
      end else begin
        if (start) snap_div[i*DIV_W +: DIV_W] <= div_next[i*DIV_W +: DIV_W];
        if (done)  act_div[i*DIV_W +: DIV_W]  <= snap_div[i*DIV_W +: DIV_W];
      end
    end
  end

  for (genvar j = 0; j < NUM_FRAC; j++) begin : g_frac
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        snap_frac[j*FRAC_W +: FRAC_W] <= '0;
        act_frac[j*FRAC_W +: FRAC_W]  <= '0;
      end else begin
        if (start) snap_frac[j*FRAC_W +: FRAC_W] <= frac_next[j*FRAC_W +: FRAC_W];
        if (done)  act_frac[j*FRAC_W +: FRAC_W]  <= snap_frac[j*FRAC_W +: FRAC_W];
      end
    end
  end

  // R3: active codes hold unless the kick window ends
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(act_div) && $stable(act_frac));
endmodule

// File: rtl/rate_kick_regs.sv
module rate_kick_regs
  import rkr_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               kick_busy,
  output logic [DIV_VW-1:0]  act_div,
  output logic [FRAC_VW-1:0] act_frac
);
  logic              wr_en, kick_req, start, done;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [DIV_VW-1:0] div_next;
  logic [FRAC_VW-1:0] frac_next;

  rkr_bus_port u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  rkr_shadow u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(req_addr), .busy(kick_busy), .rd_data(rd_data),
    .div_next(div_next), .frac_next(frac_next), .kick_req(kick_req)
  );

  rkr_kick_seq #(.LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .kick_req(kick_req),
    .busy(kick_busy), .start(start), .done(done)
  );

  rkr_active u_active (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .div_next(div_next), .frac_next(frac_next),
    .act_div(act_div), .act_frac(act_frac)
  );
endmodule

// File: tb/rate_kick_regs_test.sv
module rate_kick_regs_test;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, kick_busy;
  logic [31:0] rsp_rdata, act_div;
  logic [9:0]  act_frac;

  int vectors = 0, errors = 0, cyc = 0, kick_cyc = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] m_a = 0, m_b = 0, m_f = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rate_kick_regs #(.LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .kick_busy(kick_busy), .act_div(act_div), .act_frac(act_frac)
  );

  function automatic logic [31:0] pack_div(logic [31:0] a, logic [31:0] b);
    return {b[7:4], b[11:8], b[15:12], a[3:0], a[7:4], a[11:8], a[15:12], a[23:20]};
  endfunction
  function automatic logic [9:0] pack_frac(logic [31:0] f);
    return {f[4:0], f[12:8]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each consumed read response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected response", 64'(rsp_rdata), 64'hDEAD);
      else check("R2 readback", 64'(rsp_rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic xfer(logic wr, logic [1:0] addr, logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [1:0] addr, logic [31:0] data);
    xfer(1'b1, addr, data);
    case (addr)
      2'd0: m_a = data & 32'h00F0_FFFF;
      2'd1: m_b = data & 32'h0000_FFF0;
      2'd2: m_f = data & 32'h0000_1F1F;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] addr, logic [31:0] exp);
    exp_q.push_back(exp);
    xfer(1'b0, addr, 32'h0);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] old_div, new_div;
    logic [9:0]  old_frac, new_frac;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(kick_busy), 0);
    check("R1 act_div", 64'(act_div), 0);
    check("R1 act_frac", 64'(act_frac), 0);
    check("R1 req_ready", 64'(req_ready), 1);
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    rd(0, 0); rd(1, 0); rd(2, 0);

    // R2 field masks, R10 no kick with bit 31 clear
    wr(0, 32'hFFFF_FFFF); rd(0, 32'h00F0_FFFF);
    wr(2, 32'hFFFF_FFFF); rd(2, 32'h0000_1F1F);
    wr(1, 32'h7FFF_FFFF);
    @(negedge clk);
    check("R10 busy", 64'(kick_busy), 0);
    rd(1, 32'h0000_FFF0);
    wr(3, 32'hFFFF_FFFF); rd(3, 0);
    // R3 no kick, no change
    check("R3 act_div", 64'(act_div), 0);
    check("R3 act_frac", 64'(act_frac), 0);

    // R4 R5 R6 first kick
    wr(0, 32'h0031_2345);
    wr(2, 32'h0000_0A05);
    old_div = act_div; old_frac = act_frac;
    wr(1, 32'h8000_9870);
    kick_cyc = cyc;
    new_div = pack_div(m_a, m_b); new_frac = pack_frac(m_f);
    @(negedge clk);
    check("R4 busy", 64'(kick_busy), 1);
    wait_cyc(kick_cyc + LAT - 1);
    check("R5 busy before end", 64'(kick_busy), 1);
    check("R5 act_div before end", 64'(act_div), 64'(old_div));
    wait_cyc(kick_cyc + LAT);
    check("R5 busy cleared", 64'(kick_busy), 0);
    check("R6 act_div", 64'(act_div), 64'(new_div));
    check("R6 act_frac", 64'(act_frac), 64'(new_frac));

    // R7 R8 writes and second kick while pending
    old_div = act_div; old_frac = act_frac;
    wr(1, 32'h8000_C3A0);
    kick_cyc = cyc;
    new_div = pack_div(m_a, m_b); new_frac = pack_frac(m_f);
    wr(0, 32'h00F0_1111);
    wr(2, 32'h0000_0103);
    rd(1, 32'h8000_C3A0);
    wr(1, 32'h8000_5550);
    wait_cyc(kick_cyc + LAT - 1);
    check("R8 busy held", 64'(kick_busy), 1);
    check("R7 act_div pending", 64'(act_div), 64'(old_div));
    wait_cyc(kick_cyc + LAT);
    check("R8 busy cleared on time", 64'(kick_busy), 0);
    check("R7 act_div snapshot", 64'(act_div), 64'(new_div));
    check("R7 act_frac snapshot", 64'(act_frac), 64'(new_frac));
    repeat (3) @(negedge clk);
    check("R8 no restart", 64'(kick_busy), 0);
    rd(1, 32'h0000_5550);
    wr(1, 32'h8000_5550);
    kick_cyc = cyc;
    wait_cyc(kick_cyc + LAT);
    check("R7 later kick div", 64'(act_div), 64'(pack_div(m_a, m_b)));
    check("R7 later kick frac", 64'(act_frac), 64'(pack_frac(m_f)));

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(0, m_a);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 rsp held", 64'(rsp_valid), 1);
      check("R9 req_ready low", 64'(req_ready), 0);
      check("R9 data stable", 64'(rsp_rdata), 64'(m_a));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 rsp drained", 64'(rsp_valid), 0);
    wr(2, 32'h0000_1E1E);
    @(negedge clk);
    check("R9 write silent", 64'(rsp_valid), 0);
    rd(2, 32'h0000_1E1E);
    repeat (3) @(negedge clk);
    check("R9 queue empty", 64'(exp_q.size()), 0);
    summary();
  end
endmodule